// File: doc/BRIEF.md
# Dual-Image Configuration Loader with Signature Check

This block builds the working configuration of a chip from a write-once store. At power-up, and again each time a reload is requested, it reads two write-once images of the settings and a bank of signature slots from the one-time-programmable store. Each setting's working value is image 1 XOR image 2 XOR a built-in default. An erased store reads as zero, so a setting can be moved away from its default once through image 1 and moved back once through image 2.

A 16-bit CRC is computed over the merged values of the covered settings. The last settings hold manufacturing data and saved fault status, and the CRC leaves them out. The result is compared with the signature in the highest-numbered non-zero slot. If they match, the merged values are kept. If they differ, every setting falls back to its default and an error flag is raised. When no slot has been written, the defaults are used and no error is raised. The register file reads as zero until the load has finished and the done flag is high.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held, and at all times while a load is in progress, `done` is 0, `sig_err` is 0 and `cfg_rd_data` reads 0.
- R2: The default of setting i is (59*i + 165) mod 256. When the signature check passes, setting i reads image1[i] XOR image2[i] XOR default(i). Programming image 2 equal to image 1 therefore restores the default.
- R3: When every signature slot reads zero, all settings take their defaults and `sig_err` stays 0, whatever the images contain.
- R4: Slot s is a little-endian 16-bit word, with its low byte at address 2*NUM_SET+2*s and its high byte at the next address. The active signature is the non-zero slot with the highest s. Lower slots do not affect the result.
- R5: When the active signature differs from the computed CRC, all settings take their defaults and `sig_err` is 1 once `done` rises.
- R6: The signature is a CRC-16 with polynomial 0x1021, initial value 0xFFFF, taken MSB first with no reflection and no final XOR. It runs over the merged values of settings 0 to NUM_SET-NUM_EXCL-1 in ascending order. Changing the excluded settings never changes the check result.
- R7: A pulse on `reload_req` while `done` is 1 lowers `done`, clears `sig_err` and repeats the whole load from the current store contents. Without a request, `done` and `sig_err` hold.
- R8: `reload_req` pulses during a load are ignored, so the time from the accepted request to `done` is unchanged.
- R9: Image 1 is at store addresses 0 to NUM_SET-1 and image 2 at NUM_SET to 2*NUM_SET-1. Each load reads all addresses exactly once, in ascending order from 0. The store returns data one cycle after the address. No read occurs while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reload_req | input | 1 | One-cycle request to reload the configuration |
| otp_rd_en | output | 1 | Store read strobe |
| otp_addr | output | AW | Store byte address |
| otp_rdata | input | 8 | Store data, valid one cycle after the address |
| cfg_rd_idx | input | IW | Setting index to read |
| cfg_rd_data | output | 8 | Setting value, 0 while not done |
| done | output | 1 | Load complete, register file valid |
| sig_err | output | 1 | Signature mismatch detected on the last load |

## Verification
The properties assume that `otp_rdata` follows the address strobe with one cycle of latency. They also assume that `reload_req` comes as a short pulse and not as a level. The bench store model is a registered array that answers every strobe on the next edge. The bench changes its contents only while `done` is high. It drives `reload_req` high for single cycles, including pulses placed in the middle of a load.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_CRC    = 2'd1,
    ST_DECIDE = 2'd2,
    ST_DONE   = 2'd3
  } ld_state_e;

  // built-in default value of setting idx
  function automatic logic [7:0] cfg_default(input int unsigned idx);
    return 8'((idx * 59 + 165) % 256);
  endfunction

  // one byte of CRC-16, polynomial 0x1021, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in;
    for (int b = 7; b >= 0; b--) begin
      if (c[15] ^ d[b]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/cfg_crc_acc.sv
`timescale 1ns/1ps
module cfg_crc_acc #(
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import cfg_loader_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = INIT;
    else if (en) crc_d = crc16_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
module cfg_regfile #(
  parameter  int NUM_SET = 16,
  localparam int IW      = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          def_load,
  input  logic [IW-1:0] rd_a_idx,
  output logic [7:0]    rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [7:0]    rd_b_data
);
  import cfg_loader_pkg::*;

  logic [7:0] mem [NUM_SET];

  for (genvar g = 0; g < NUM_SET; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (32'(wr_idx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem[g] <= '0;
      else if (def_load) mem[g] <= cfg_default(g);
      else if (ent_we)   mem[g] <= wr_data;
    end
  end

  assign rd_a_data = (32'(rd_a_idx) < NUM_SET) ? mem[rd_a_idx] : 8'h00;
  assign rd_b_data = (32'(rd_b_idx) < NUM_SET) ? mem[rd_b_idx] : 8'h00;
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader #(
  parameter  int NUM_SET  = 16,
  parameter  int NUM_EXCL = 2,
  parameter  int NUM_SLOT = 8,
  localparam int TOTAL    = 2 * NUM_SET + 2 * NUM_SLOT,
  localparam int AW       = $clog2(TOTAL),
  localparam int IW       = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_req,
  output logic          otp_rd_en,
  output logic [AW-1:0] otp_addr,
  input  logic [7:0]    otp_rdata,
  input  logic [IW-1:0] cfg_rd_idx,
  output logic [7:0]    cfg_rd_data,
  output logic          done,
  output logic          sig_err
);
  import cfg_loader_pkg::*;

  localparam int NUM_COV   = NUM_SET - NUM_EXCL;
  localparam int IMG2_BASE = NUM_SET;
  localparam int SLOT_BASE = 2 * NUM_SET;

  // reset: asynchronous assertion, synchronous release
  logic rst_s1, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      srst_n <= rst_s1;
    end
  end

  ld_state_e     state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cap_vld_q, cap_vld_d;
  logic [AW-1:0] cap_addr_q, cap_addr_d;
  logic [7:0]    slot_lo_q, slot_lo_d;
  logic [15:0]   sig_q, sig_d;
  logic          sig_seen_q, sig_seen_d;
  logic [IW-1:0] crc_idx_q, crc_idx_d;
  logic          err_q, err_d;

  logic          rf_we, def_load, crc_clr, crc_en;
  logic [IW-1:0] rf_widx, rf_aidx;
  logic [7:0]    rf_wdata, rf_adata, rf_bdata;
  logic [15:0]   crc_val;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    slot_lo_d  = slot_lo_q;
    sig_d      = sig_q;
    sig_seen_d = sig_seen_q;
    crc_idx_d  = crc_idx_q;
    err_d      = err_q;
    cap_vld_d  = (state_q == ST_READ);
    cap_addr_d = cnt_q;
    rf_we      = 1'b0;
    rf_widx    = '0;
    rf_wdata   = '0;
    def_load   = 1'b0;
    crc_clr    = 1'b0;
    crc_en     = 1'b0;
    rf_aidx    = crc_idx_q;

    unique case (state_q)
      ST_READ: begin
        if (cnt_q == AW'(TOTAL - 1)) begin
          state_d   = ST_CRC;
          crc_idx_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CRC: begin
        crc_en = 1'b1;
        if (crc_idx_q == IW'(NUM_COV - 1)) state_d = ST_DECIDE;
        else                               crc_idx_d = crc_idx_q + 1'b1;
      end
      ST_DECIDE: begin
        if (!sig_seen_q) begin
          def_load = 1'b1;
        end else if (crc_val != sig_q) begin
          def_load = 1'b1;
          err_d    = 1'b1;
        end
        state_d = ST_DONE;
      end
      ST_DONE: begin
        if (reload_req) begin
          state_d    = ST_READ;
          cnt_d      = '0;
          err_d      = 1'b0;
          sig_d      = '0;
          sig_seen_d = 1'b0;
          crc_clr    = 1'b1;
        end
      end
      default: state_d = ST_DONE;
    endcase

    // returned store byte, one cycle after its address
    if (cap_vld_q) begin
      if (cap_addr_q < AW'(IMG2_BASE)) begin
        rf_we    = 1'b1;
        rf_widx  = IW'(cap_addr_q);
        rf_wdata = otp_rdata ^ cfg_default(32'(cap_addr_q));
      end else if (cap_addr_q < AW'(SLOT_BASE)) begin
        rf_aidx  = IW'(cap_addr_q - AW'(IMG2_BASE));
        rf_we    = 1'b1;
        rf_widx  = rf_aidx;
        rf_wdata = rf_adata ^ otp_rdata;
      end else if (!cap_addr_q[0]) begin
        slot_lo_d = otp_rdata;
      end else if ({otp_rdata, slot_lo_q} != 16'h0000) begin
        sig_d      = {otp_rdata, slot_lo_q};
        sig_seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= ST_READ;
      cnt_q      <= '0;
      cap_vld_q  <= 1'b0;
      cap_addr_q <= '0;
      slot_lo_q  <= '0;
      sig_q      <= '0;
      sig_seen_q <= 1'b0;
      crc_idx_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      cap_vld_q  <= cap_vld_d;
      cap_addr_q <= cap_addr_d;
      slot_lo_q  <= slot_lo_d;
      sig_q      <= sig_d;
      sig_seen_q <= sig_seen_d;
      crc_idx_q  <= crc_idx_d;
      err_q      <= err_d;
    end
  end

  cfg_crc_acc #(.INIT(16'hFFFF)) u_crc (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (rf_adata),
    .crc   (crc_val)
  );

  cfg_regfile #(.NUM_SET(NUM_SET)) u_rf (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (rf_we),
    .wr_idx    (rf_widx),
    .wr_data   (rf_wdata),
    .def_load  (def_load),
    .rd_a_idx  (rf_aidx),
    .rd_a_data (rf_adata),
    .rd_b_idx  (cfg_rd_idx),
    .rd_b_data (rf_bdata)
  );

  assign otp_rd_en   = (state_q == ST_READ) && srst_n;
  assign otp_addr    = cnt_q;
  assign done        = (state_q == ST_DONE);
  assign sig_err     = err_q;
  assign cfg_rd_data = done ? rf_bdata : 8'h00;
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk #(
  parameter int AW    = 6,
  parameter int TOTAL = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reload_req,
  input logic          otp_rd_en,
  input logic [AW-1:0] otp_addr,
  input logic          done,
  input logic          sig_err
);
  // no store reads once the register file is valid
  p_no_read_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    otp_rd_en |-> !done);

  // addresses stay inside the store map
  p_addr_in_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    otp_rd_en |-> (32'(otp_addr) < TOTAL));

  // consecutive reads step up by one
  p_addr_ascending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_rd_en && $past(otp_rd_en)) |-> (otp_addr == $past(otp_addr) + 1'b1));

  // each load starts at address 0
  p_load_from_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_rd_en) |-> (otp_addr == '0));

  // error flag only reported with a finished load
  p_err_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> done);

  // finished state holds until a reload is asked for
  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reload_req) |=> (done && $stable(sig_err)));

  // a request during a load does not finish it early
  p_busy_ignores_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && otp_rd_en && reload_req) |=> !done);
endmodule

bind cfg_loader cfg_loader_chk #(.AW(AW), .TOTAL(TOTAL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reload_req (reload_req),
  .otp_rd_en  (otp_rd_en),
  .otp_addr   (otp_addr),
  .done       (done),
  .sig_err    (sig_err)
);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  localparam int N     = 16;
  localparam int NE    = 2;
  localparam int NS    = 8;
  localparam int TOTAL = 2 * N + 2 * NS;
  localparam int NCOV  = N - NE;
  localparam int AW    = $clog2(TOTAL);
  localparam int IW    = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reload_req = 1'b0;
  logic          otp_rd_en;
  logic [AW-1:0] otp_addr;
  logic [7:0]    otp_rdata;
  logic [IW-1:0] cfg_rd_idx = '0;
  logic [7:0]    cfg_rd_data;
  logic          done, sig_err;

  int checks = 0;
  int fails  = 0;

  logic [7:0] otp_mem [TOTAL];
  logic [7:0] exp_reg [N];
  logic       exp_err;

  always #10 clk = ~clk;   // 50 MHz

  always_ff @(posedge clk) if (otp_rd_en) otp_rdata <= otp_mem[otp_addr];

  cfg_loader #(.NUM_SET(N), .NUM_EXCL(NE), .NUM_SLOT(NS)) uut (
    .clk(clk), .rst_n(rst_n), .reload_req(reload_req),
    .otp_rd_en(otp_rd_en), .otp_addr(otp_addr), .otp_rdata(otp_rdata),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .done(done), .sig_err(sig_err)
  );

  // vector: seed1, seed2, slot mode, slot number, expected error
  // modes: 0 no slot, 1 good, 2 bad, 3 bad in slot 0 + good in slot, 4 good in slot 0 + bad in slot
  localparam int NV = 7;
  localparam logic [22:0] VEC [NV] = '{
    {8'h00, 8'h00, 3'd0, 3'd0, 1'b0},
    {8'h5A, 8'h00, 3'd1, 3'd0, 1'b0},
    {8'h5A, 8'h33, 3'd1, 3'd7, 1'b0},
    {8'h5A, 8'h33, 3'd2, 3'd2, 1'b1},
    {8'h11, 8'hC4, 3'd3, 3'd5, 1'b0},
    {8'h11, 8'hC4, 3'd4, 3'd6, 1'b1},
    {8'h77, 8'h00, 3'd0, 3'd0, 1'b0}
  };

  function automatic logic [7:0] tdef(input int i);
    return 8'((59 * i + 165) % 256);
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    if (seed == 8'h00) return 8'h00;
    return 8'((int'(seed) * 7 + i * 29) % 256) ^ seed;
  endfunction

  function automatic logic [15:0] tcrc_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  function automatic logic [15:0] merged_crc();
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < NCOV; i++)
      c = tcrc_byte(c, otp_mem[i] ^ otp_mem[N + i] ^ tdef(i));
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_slot(input int s, input logic [15:0] w);
    otp_mem[2 * N + 2 * s]     = w[7:0];
    otp_mem[2 * N + 2 * s + 1] = w[15:8];
  endtask

  // fill the store and work out the expected outcome
  task automatic prog(input logic [7:0] s1, input logic [7:0] s2,
                      input int mode, input int slot);
    logic [15:0] good;
    for (int a = 0; a < TOTAL; a++) otp_mem[a] = 8'h00;
    for (int i = 0; i < N; i++) begin
      otp_mem[i]     = pat(s1, i);
      otp_mem[N + i] = pat(s2, i);
    end
    good = merged_crc();
    case (mode)
      1: put_slot(slot, good);
      2: put_slot(slot, ~good);
      3: begin put_slot(0, ~good); put_slot(slot, good); end
      4: begin put_slot(0, good);  put_slot(slot, ~good); end
      default: ;
    endcase
    exp_err = (mode == 2) || (mode == 4);
    for (int i = 0; i < N; i++)
      exp_reg[i] = (mode == 0 || exp_err) ? tdef(i) : (otp_mem[i] ^ otp_mem[N + i] ^ tdef(i));
  endtask

  task automatic reload(output int cyc);
    @(negedge clk) reload_req = 1'b1;
    @(negedge clk) reload_req = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "timeout waiting for done", 0, 1);
  endtask

  task automatic check_regs(input string tag);
    int bad_idx;
    logic [7:0] bad_act;
    bad_idx = -1;
    bad_act = '0;
    for (int i = 0; i < N; i++) begin
      cfg_rd_idx = IW'(i);
      #1;
      if (cfg_rd_data !== exp_reg[i] && bad_idx < 0) begin
        bad_idx = i;
        bad_act = cfg_rd_data;
      end
    end
    if (bad_idx < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s setting %0d", tag, bad_idx), bad_act, exp_reg[bad_idx]);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc, l1, l2;
    for (int a = 0; a < TOTAL; a++) otp_mem[a] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(sig_err == 1'b0, "R1 sig_err in reset", sig_err, 0);
    check(cfg_rd_data == 8'h00, "R1 data in reset", cfg_rd_data, 0);
    rst_n = 1'b1;

    // R3: power-up from a blank store
    prog(8'h00, 8'h00, 0, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R3 power-up load finished", done, 1);
    check(sig_err == 1'b0, "R3 blank store no error", sig_err, 0);
    check_regs("R3 blank store defaults");

    // vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      prog(VEC[v][22:15], VEC[v][14:7], int'(VEC[v][6:4]), int'(VEC[v][3:1]));
      check(exp_err == VEC[v][0], $sformatf("vector %0d table consistency", v), exp_err, VEC[v][0]);
      reload(cyc);
      check(sig_err == exp_err, $sformatf("R4 R5 vector %0d error flag", v), sig_err, exp_err);
      check_regs($sformatf("R2 R3 R5 vector %0d settings", v));
    end

    // R2: image 2 equal to image 1 reverts to defaults
    prog(8'h6B, 8'h6B, 1, 1);
    reload(cyc);
    check(sig_err == 1'b0, "R2 revert no error", sig_err, 0);
    for (int i = 0; i < N; i++)
      check(exp_reg[i] == tdef(i), "R2 revert expectation", exp_reg[i], tdef(i));
    check_regs("R2 revert restores defaults");

    // R6: excluded settings do not change the check
    prog(8'h5A, 8'h33, 1, 0);
    otp_mem[N - 1] = otp_mem[N - 1] ^ 8'hFF;
    otp_mem[N - 2] = otp_mem[N - 2] ^ 8'h0F;
    exp_reg[N - 1] = exp_reg[N - 1] ^ 8'hFF;
    exp_reg[N - 2] = exp_reg[N - 2] ^ 8'h0F;
    reload(cyc);
    check(sig_err == 1'b0, "R6 excluded change keeps signature", sig_err, 0);
    check_regs("R6 excluded settings merged");

    // R6: a covered setting change breaks the check
    otp_mem[0] = otp_mem[0] ^ 8'h01;
    for (int i = 0; i < N; i++) exp_reg[i] = tdef(i);
    reload(cyc);
    check(sig_err == 1'b1, "R6 covered change flags error", sig_err, 1);
    check_regs("R6 covered change defaults");

    // R1 R7: during a reload the block reads as unavailable
    prog(8'h5A, 8'h00, 1, 3);
    @(negedge clk) reload_req = 1'b1;
    @(negedge clk) reload_req = 1'b0;
    cfg_rd_idx = '0;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done low while loading", done, 0);
    check(cfg_rd_data == 8'h00, "R1 data hidden while loading", cfg_rd_data, 0);
    check(sig_err == 1'b0, "R7 error cleared on reload", sig_err, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check_regs("R7 reload picks up new store contents");

    // R7: state holds without a request
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R7 done holds", done, 1);

    // R8: requests during a load are ignored
    reload(l1);
    @(negedge clk) reload_req = 1'b1;
    @(negedge clk) reload_req = 1'b0;
    l2 = 1;
    while (!done && l2 < 2000) begin
      @(negedge clk);
      l2++;
      reload_req = (l2 == 5 || l2 == 20);
    end
    reload_req = 1'b0;
    check(l2 == l1, "R8 load time with extra requests", l2, l1);
    check(done == 1'b1, "R8 load completed", done, 1);
    check_regs("R8 settings after disturbed load");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule